// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block collects one-cycle raise pulses from thirteen interrupt sources and presents one interrupt request line to a processor. Each source has a pending flag. A raise is kept only for a source that software has opened: its bit is set either in the enable mask or in the non-maskable select mask. The request line stays high while any flag is set.

Software sees the block as four word registers on a simple synchronous bus. The level register gives the index of the most urgent pending source; a lower index is more urgent. The clear register drops flags by mask. The two mask registers read back what was stored. Writing a new enable mask also drops the pending flag of every source that the new mask closes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all pending flags and both masks are zero, `cpuIrq` is low, and reads of the enable register (address 3) and the select register (address 2) return 0.
- R2: A raise on a source whose enable bit and select bit are both 0 is dropped and leaves no pending flag.
- R3: A raise on a source whose enable bit is 1 sets its pending flag at the next clock edge.
- R4: A raise on a source whose select bit (address 2) is 1 sets its pending flag, even when its enable bit is 0.
- R5: `cpuIrq` is high in exactly the cycles where at least one pending flag is set, and it drops once the last flag is cleared.
- R6: A read of address 0 returns, zero-extended, the smallest index 0 to 12 whose pending flag is set.
- R7: A write to address 0 or 1 does not change any mask. A write to address 1 clears every pending flag whose data bit is 1, and a read of address 1 returns 0.
- R8: The enable register (address 3) and the select register (address 2) read back the last value written to bits 12:0, and bits 15:13 read as 0.
- R9: A write to the enable register clears the pending flag of every source whose new enable bit is 0, whatever its select bit.
- R10: When an accepted raise and a clear of the same source fall in the same cycle, the pending flag ends up set.
- R11: A read of address 0 returns 0x00FF when no flag is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| raiseIn | input | 13 | Raise pulse for each source, one bit per source |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | 2 | Register select: 0 level, 1 clear, 2 select mask, 3 enable mask |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr`, combinational |
| cpuIrq | output | 1 | Interrupt request to the processor |

## Verification
A wrong pending flag shows up in the level readout and on `cpuIrq` in the cycle right after the edge that should have changed it. A flag that was wrongly kept or wrongly dropped alters the level code or the line at once. A wrong mask bit stays hidden until a raise arrives on that source, so the bench reads every mask back directly. It also drives raises on both open and closed sources, so that a bad gate becomes a wrong level code one cycle later.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LEVEL  = 2'd0,
    SEL_CLEAR  = 2'd1,
    SEL_NMI    = 2'd2,
    SEL_ENABLE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    clearWr;
    logic    nmiWr;
    logic    enableWr;
    regSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/prio_irq_ctrl_dec.sv
module prio_irq_ctrl_dec
  import prio_irq_pkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          stb
);
  regSel_e sel;

  always_comb begin
    sel          = regSel_e'(busAddr);
    stb.rdSel    = sel;
    stb.clearWr  = busWe && (sel == SEL_CLEAR);
    stb.nmiWr    = busWe && (sel == SEL_NMI);
    stb.enableWr = busWe && (sel == SEL_ENABLE);
  end
endmodule

// File: rtl/prio_irq_ctrl_dp.sv
module prio_irq_ctrl_dp
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int DATA_W  = 16,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] raiseIn,
  input  logic [DATA_W-1:0]  wrData,
  input  strobes_t           stb,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] pendQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic [NUM_SRC-1:0] nmiQ,
  output logic [CODE_W-1:0]  levelCode,
  output logic               anyPend
);
  localparam logic [CODE_W-1:0] NONE_CODE = {CODE_W{1'b1}};
  localparam int PAD_W = DATA_W - NUM_SRC;
  localparam int CPAD_W = DATA_W - CODE_W;

  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] accepted;
  logic [NUM_SRC-1:0] kept;
  logic [NUM_SRC-1:0] pendD;

  assign wrBits   = wrData[NUM_SRC-1:0];
  assign accepted = raiseIn & (enQ | nmiQ);

  always_comb begin
    kept = pendQ;
    if (stb.clearWr)  kept = kept & ~wrBits;
    if (stb.enableWr) kept = kept & wrBits;
    pendD = kept | accepted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      enQ   <= '0;
      nmiQ  <= '0;
    end else begin
      pendQ <= pendD;
      if (stb.enableWr) enQ  <= wrBits;
      if (stb.nmiWr)    nmiQ <= wrBits;
    end
  end

  always_comb begin
    levelCode = NONE_CODE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendQ[i]) levelCode = CODE_W'(i);
    end
  end

  assign anyPend = |pendQ;

  always_comb begin
    unique case (stb.rdSel)
      SEL_LEVEL:  rdData = {{CPAD_W{1'b0}}, levelCode};
      SEL_CLEAR:  rdData = '0;
      SEL_NMI:    rdData = {{PAD_W{1'b0}}, nmiQ};
      SEL_ENABLE: rdData = {{PAD_W{1'b0}}, enQ};
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int DATA_W  = 16,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] raiseIn,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               cpuIrq
);
  strobes_t           stb;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] nmiQ;
  logic [CODE_W-1:0]  levelCode;
  logic               anyPend;

  prio_irq_ctrl_dec u_dec (
    .busWe   (busWe),
    .busAddr (busAddr),
    .stb     (stb)
  );

  prio_irq_ctrl_dp #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .CODE_W  (CODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .raiseIn   (raiseIn),
    .wrData    (busWrData),
    .stb       (stb),
    .rdData    (busRdData),
    .pendQ     (pendQ),
    .enQ       (enQ),
    .nmiQ      (nmiQ),
    .levelCode (levelCode),
    .anyPend   (anyPend)
  );

  assign cpuIrq = anyPend;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_SRC = 13,
  parameter int DATA_W  = 16,
  parameter int CODE_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] raiseIn,
  input logic               busWe,
  input logic [1:0]         busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic [NUM_SRC-1:0] pendQ,
  input logic [NUM_SRC-1:0] enQ,
  input logic [NUM_SRC-1:0] nmiQ,
  input logic [CODE_W-1:0]  levelCode,
  input logic               cpuIrq
);
  localparam logic [CODE_W-1:0] NONE_CODE = {CODE_W{1'b1}};

  AST_DROP_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(enQ | nmiQ)) == '0)); // R2

  AST_ACCEPT_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(raiseIn & (enQ | nmiQ)) & ~pendQ) == '0)); // R10

  AST_LINE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (levelCode != NONE_CODE)); // R5

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (levelCode == NONE_CODE) || (int'(levelCode) < NUM_SRC)); // R6

  AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd3)
      |=> ((pendQ & ~enQ & ~$past(raiseIn)) == '0)); // R9

  AST_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd1)
      |=> ((pendQ & $past(busWrData[NUM_SRC-1:0]) & ~$past(raiseIn)) == '0)); // R7

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr[1]) |=> ($stable(enQ) && $stable(nmiQ))); // R7
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .CODE_W  (CODE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .raiseIn   (raiseIn),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .pendQ     (pendQ),
  .enQ       (enQ),
  .nmiQ      (nmiQ),
  .levelCode (levelCode),
  .cpuIrq    (cpuIrq)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NS = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] raiseIn = '0;
  logic          busWe = 1'b0;
  logic [1:0]    busAddr = 2'd0;
  logic [15:0]   busWrData = '0;
  logic [15:0]   busRdData;
  logic          cpuIrq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] expData;
    logic        expIrq;
    string       tag;
  } item_t;

  item_t sbq[$];

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .raiseIn   (raiseIn),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .cpuIrq    (cpuIrq)
  );

  // monitor: compares one queued item per cycle, away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (busRdData !== it.expData || cpuIrq !== it.expIrq) begin
        fails++;
        $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                 it.tag, busRdData, cpuIrq, it.expData, it.expIrq);
      end
    end
  end

  task automatic step(input logic we, input logic [1:0] a,
                      input logic [15:0] d, input logic [NS-1:0] r);
    @(posedge clk);
    #1;
    busWe = we;
    busAddr = a;
    busWrData = d;
    raiseIn = r;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(1'b1, a, d, '0);
  endtask

  task automatic raise(input logic [NS-1:0] r);
    step(1'b0, 2'd0, '0, r);
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e,
                    input logic ei, input string tag);
    item_t it;
    step(1'b0, a, '0, '0);
    it.expData = e;
    it.expIrq = ei;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    rd(2'd0, 16'h00FF, 1'b0, "R1 R11 level after reset");
    rd(2'd3, 16'h0000, 1'b0, "R1 enable after reset");
    rd(2'd2, 16'h0000, 1'b0, "R1 select after reset");

    raise(13'h0008);
    rd(2'd0, 16'h00FF, 1'b0, "R2 closed raise dropped");

    wr(2'd3, 16'h0021);
    raise(13'h0020);
    rd(2'd0, 16'h0005, 1'b1, "R3 R5 enabled raise latched");

    wr(2'd2, 16'h0200);
    raise(13'h0200);
    rd(2'd0, 16'h0005, 1'b1, "R6 lower index wins");
    rd(2'd2, 16'h0200, 1'b1, "R8 select readback");

    raise(13'h0001);
    rd(2'd0, 16'h0000, 1'b1, "R6 source 0 most urgent");

    wr(2'd1, 16'h0001);
    rd(2'd0, 16'h0005, 1'b1, "R7 clear source 0");
    wr(2'd1, 16'h0020);
    rd(2'd0, 16'h0009, 1'b1, "R4 select-only source pending");
    rd(2'd3, 16'h0021, 1'b1, "R7 clear leaves enable mask");
    wr(2'd1, 16'h0200);
    rd(2'd0, 16'h00FF, 1'b0, "R5 R11 line drops when empty");

    wr(2'd3, 16'h1FFF);
    rd(2'd3, 16'h1FFF, 1'b0, "R8 enable readback");
    raise(13'h0284);
    rd(2'd0, 16'h0002, 1'b1, "R6 three pending");
    wr(2'd3, 16'h1F7B);
    rd(2'd0, 16'h0009, 1'b1, "R9 closed sources dropped");
    wr(2'd3, 16'h1D7B);
    rd(2'd0, 16'h00FF, 1'b0, "R9 select bit does not protect");
    rd(2'd3, 16'h1D7B, 1'b0, "R8 enable readback after narrowing");

    step(1'b1, 2'd1, 16'h0010, 13'h0010);
    rd(2'd0, 16'h0004, 1'b1, "R10 raise beats clear");
    wr(2'd1, 16'h0010);
    rd(2'd0, 16'h00FF, 1'b0, "R7 clear after tie");

    raise(13'h1000);
    rd(2'd0, 16'h000C, 1'b1, "R6 highest index source");
    raise(13'h0008);
    rd(2'd0, 16'h0003, 1'b1, "R6 new lower index takes over");
    wr(2'd1, 16'h1008);
    rd(2'd0, 16'h00FF, 1'b0, "R7 multi-bit clear");

    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'h1FFF, 1'b0, "R8 upper bits read zero");
    rd(2'd1, 16'h0000, 1'b0, "R7 clear register reads zero");

    wr(2'd0, 16'hFFFF);
    rd(2'd3, 16'h1D7B, 1'b0, "R7 level write leaves enable");
    rd(2'd2, 16'h1FFF, 1'b0, "R7 level write leaves select");

    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0000);
    raise(13'h1FFF);
    rd(2'd0, 16'h00FF, 1'b0, "R2 all sources closed");

    step(1'b0, 2'd0, '0, '0);
    @(posedge clk);
    #1;
    finish_run();
  end
endmodule